// File: doc/BRIEF.md
# PLL Coefficient Reprogramming Sequencer

This block moves a clock synthesiser from its present divider setting to a new one without a glitch on the clock it drives. It is given the target input divider M, feedback multiplier N and post divider PL, plus the reference frequency in kHz. On a start pulse it carries out the full register sequence through a simple register master port. That port holds a configuration word, a packed coefficient word, a VCO/bypass select word and an output-divider word.

When the synthesiser is running, the block prefers to reach the new N by gradual sliding. Sliding is done by an external slide engine, which this block drives through a request/complete handshake. When only N differs, a single slide is enough. Otherwise the block slides N down to the minimum-VCO value and parks the output on bypass with the output divider briefly at 1:2. It then rewrites the coefficients, waits for lock, returns to the VCO with the divider restored to 1:1, and slides up to the target N. If any step of such a sliding attempt fails, the whole sequence runs once more with no slides. Done pulses at the end, and the error output holds the outcome of the last attempt.

Top module: `pll_reprog_seq`

## Requirements
- R1: Register select codes are config=0, coefficient=1, VCO select=2, output divider=3. The coefficient word packs M in [7:0], N in [15:8] and PL in [21:16]. When the config enable bit (bit 0) reads 1 and both M and PL equal the values in the coefficient word, the block issues exactly one slide to the target N and writes no other register.
- R2: When enable reads 1 and M or PL differs, the block first slides to ceil(M_old * VCO_MIN_KHZ / ref_khz), saturated to 255, where M_old is the M field that was read back.
- R3: Before the coefficient word is written, the output-divider field [13:8] is written to 2. After that write at least SETTLE_US microseconds pass, and then select bit 0 is cleared. At the coefficient write, select bit 0 and enable are both 0.
- R4: If the power-down bit (config bit 1) is set, it is cleared. Enable is then cleared and the coefficient word is written with the target M and PL. Its N field is the minimum-VCO value computed from the new M in a sliding attempt, or the target N otherwise. Enable is then set again.
- R5: A set lock-detect-off bit (config bit 4) is cleared. The block waits up to LOCK_US microseconds for the lock bit (config bit 17), and the attempt fails if lock does not appear.
- R6: After lock, select bit 0 is set. If the divider field is non-zero, then after SETTLE_US the field is written to 0 (divide by 1) in two consecutive writes.
- R7: A sliding attempt that passes the restore ends with a slide to the target N.
- R8: A failed slide or lock timeout in a sliding attempt causes exactly one rerun with no slides. That rerun always performs the full bypass path.
- R9: done is a one-cycle pulse per accepted start. err changes only while done is high and is 1 only if the final attempt failed.
- R10: While idle, the block makes no register access and no slide request. A start pulse arriving while a sequence is running is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a reprogramming sequence |
| m_in | input | 8 | Target input divider M |
| n_in | input | 8 | Target feedback multiplier N |
| pl_in | input | 6 | Target post divider PL |
| ref_khz | input | REF_W | Reference frequency in kHz |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Outcome of the last attempt, 1 = failed |
| reg_req | output | 1 | Register access this cycle |
| reg_wr | output | 1 | 1 = write, 0 = read |
| reg_addr | output | 2 | Register select code |
| reg_wdata | output | 32 | Write data |
| reg_rdata | input | 32 | Read data, valid in the cycle of the access |
| slide_go | output | 1 | One-cycle request to the slide engine |
| slide_ndiv | output | 8 | N the slide engine should reach |
| slide_done | input | 1 | Slide engine completion pulse |
| slide_fail | input | 1 | Slide failed, qualified by slide_done |

## Verification
The bench builds the block with US_CYCLES=4, so a microsecond is four clocks. This shrinks the 300 µs lock window to 1200 cycles, which makes a lock timeout followed by a non-sliding rerun cheap enough to run both attempts to completion. The 2 µs settle waits become 8 cycles, so the bench can measure the gap between the divider-halving write and the bypass write directly. Reference values of 12000, 12500 and 38400 kHz give minimum-VCO N results that both do and do not divide exactly.

// File: rtl/pll_reprog_pkg.sv
// Shared register map, field positions and sequencer states.
// Assumes a 32-bit register word and 2-bit register select.
package pll_reprog_pkg;
    localparam logic [1:0] A_CFG   = 2'd0;
    localparam logic [1:0] A_COEFF = 2'd1;
    localparam logic [1:0] A_SEL   = 2'd2;
    localparam logic [1:0] A_ODIV  = 2'd3;

    localparam int M_W  = 8;
    localparam int N_W  = 8;
    localparam int PL_W = 6;
    localparam int M_LSB  = 0;
    localparam int N_LSB  = 8;
    localparam int PL_LSB = 16;

    localparam int CFG_EN   = 0;
    localparam int CFG_PWDN = 1;
    localparam int CFG_LDO  = 4;
    localparam int CFG_LOCK = 17;
    localparam int SEL_VCO  = 0;
    localparam int ODIV_LSB = 8;
    localparam int ODIV_W   = 6;

    typedef enum logic [5:0] {
        ST_IDLE, ST_RD_COEFF, ST_RD_CFG, ST_DIV_OLD, ST_SLIDE_LO, ST_SLIDE_ONLY,
        ST_OD_RD, ST_OD_WR, ST_BYP_WAIT, ST_SEL_RD, ST_SEL_WR,
        ST_PD_RD, ST_PD_WR, ST_PD_RB, ST_PD_WAIT,
        ST_DIS_RD, ST_DIS_WR, ST_DIV_NEW, ST_COEFF_WR,
        ST_EN_RD, ST_EN_WR, ST_LDO_RD, ST_LDO_WR, ST_LOCK,
        ST_VSEL_RD, ST_VSEL_WR, ST_RST_RD, ST_RST_WAIT, ST_RST_WR1, ST_RST_WR2,
        ST_RST_RB, ST_SLIDE_UP, ST_FAIL, ST_DONE
    } seq_st_e;
endpackage

// File: rtl/pll_reprog_ceildiv.sv
// Sequential restoring divider returning ceil(num/den), one quotient bit
// per cycle. Assumes den is non-zero; go is ignored while busy.
module pll_reprog_ceildiv #(
    parameter int NUM_W = 28,
    parameter int DEN_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             ready,
    output logic [NUM_W:0]   quo
);
    localparam int QW = NUM_W + 1;
    localparam int CW = $clog2(QW + 1);

    logic [QW-1:0]    q_q;
    logic [DEN_W-1:0] rem_q;
    logic [CW-1:0]    cnt_q;
    logic             busy_q;
    logic [DEN_W:0]   trial;
    logic [DEN_W:0]   diff;
    logic             fits;

    // Partial remainder with the next dividend bit shifted in.
    always_comb begin
        trial = {rem_q, q_q[QW-1]};
        diff  = trial - {1'b0, den};
        fits  = trial >= {1'b0, den};
    end

    // Iteration state: loads the biased dividend and shifts one bit per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_q    <= '0;
            rem_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            ready  <= 1'b0;
        end else begin
            ready <= 1'b0;
            if (go && !busy_q) begin
                q_q    <= QW'(num) + QW'(den) - QW'(1);
                rem_q  <= '0;
                cnt_q  <= CW'(QW);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                q_q   <= {q_q[QW-2:0], fits};
                rem_q <= fits ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
                cnt_q <= cnt_q - CW'(1);
                if (cnt_q == CW'(1)) begin
                    busy_q <= 1'b0;
                    ready  <= 1'b1;
                end
            end
        end
    end

    assign quo = q_q;
endmodule

// File: rtl/pll_reprog_timer.sv
// Down-counting delay timer. load sets the count; expired is high once it
// has counted down to zero. Assumes len is at least 1.
module pll_reprog_timer #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    // Counter: reload on request, otherwise count down and hold at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt_q <= '0;
        else if (load)             cnt_q <= len;
        else if (cnt_q != '0)      cnt_q <= cnt_q - CNT_W'(1);
    end

    assign expired = (cnt_q == '0) && !load;
endmodule

// File: rtl/pll_reprog_seq.sv
// Top-level reprogramming sequencer. Drives a register master port with
// zero-wait reads (read data valid in the access cycle) and an external
// slide engine by a go/done handshake. US_CYCLES is clocks per microsecond.
module pll_reprog_seq
    import pll_reprog_pkg::*;
#(
    parameter int US_CYCLES   = 100,
    parameter int SETTLE_US   = 2,
    parameter int LOCK_US     = 300,
    parameter int VCO_MIN_KHZ = 1000000,
    parameter int REF_W       = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [7:0]       m_in,
    input  logic [7:0]       n_in,
    input  logic [5:0]       pl_in,
    input  logic [REF_W-1:0] ref_khz,
    output logic             done,
    output logic             err,
    output logic             reg_req,
    output logic             reg_wr,
    output logic [1:0]       reg_addr,
    output logic [31:0]      reg_wdata,
    input  logic [31:0]      reg_rdata,
    output logic             slide_go,
    output logic [7:0]       slide_ndiv,
    input  logic             slide_done,
    input  logic             slide_fail
);
    localparam int LOCK_CYC   = LOCK_US * US_CYCLES;
    localparam int SETTLE_CYC = SETTLE_US * US_CYCLES;
    localparam int TW         = $clog2(LOCK_CYC + 1);
    localparam int NUM_W      = M_W + $clog2(VCO_MIN_KHZ + 1);
    localparam int N_MAX      = (1 << N_W) - 1;

    seq_st_e          st, nxt;
    logic             allow_q, issued_q, err_q;
    logic [M_W-1:0]   tgt_m, old_m;
    logic [N_W-1:0]   tgt_n, nlo_q;
    logic [PL_W-1:0]  tgt_pl, old_pl;
    logic [REF_W-1:0] ref_q;
    logic [31:0]      rd_q;
    logic             capture;
    logic             tmr_load, tmr_exp;
    logic [TW-1:0]    tmr_len;
    logic             div_go, div_rdy;
    logic [M_W-1:0]   div_m;
    logic [NUM_W:0]   div_quo;
    logic [N_W-1:0]   div_sat;
    logic             in_slide;
    logic             busy;

    pll_reprog_ceildiv #(.NUM_W(NUM_W), .DEN_W(REF_W)) u_div (
        .clk(clk), .rst_n(rst_n), .go(div_go),
        .num(NUM_W'(div_m) * NUM_W'(VCO_MIN_KHZ)), .den(ref_q),
        .ready(div_rdy), .quo(div_quo)
    );

    pll_reprog_timer #(.CNT_W(TW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .len(tmr_len), .expired(tmr_exp)
    );

    // Minimum-VCO N, saturated to the N field width.
    assign div_sat = (div_quo > (NUM_W+1)'(N_MAX)) ? N_W'(N_MAX) : div_quo[N_W-1:0];
    assign in_slide = (st == ST_SLIDE_LO) || (st == ST_SLIDE_ONLY) || (st == ST_SLIDE_UP);
    assign busy = (st != ST_IDLE);

    // Next state, register port, slide request, timer and divider controls.
    always_comb begin
        nxt        = st;
        reg_req    = 1'b0;
        reg_wr     = 1'b0;
        reg_addr   = A_CFG;
        reg_wdata  = rd_q;
        capture    = 1'b0;
        tmr_load   = 1'b0;
        tmr_len    = TW'(SETTLE_CYC);
        div_go     = 1'b0;
        div_m      = tgt_m;
        slide_go   = in_slide && !issued_q;
        slide_ndiv = (st == ST_SLIDE_LO) ? nlo_q : tgt_n;
        done       = 1'b0;
        case (st)
            ST_IDLE:     if (start) nxt = ST_RD_COEFF;
            ST_RD_COEFF: begin
                reg_req = 1'b1; reg_addr = A_COEFF; nxt = ST_RD_CFG;
            end
            ST_RD_CFG: begin
                reg_req = 1'b1; reg_addr = A_CFG;
                if (allow_q && reg_rdata[CFG_EN]) begin
                    if (tgt_m == old_m && tgt_pl == old_pl) nxt = ST_SLIDE_ONLY;
                    else begin
                        div_go = 1'b1; div_m = old_m; nxt = ST_DIV_OLD;
                    end
                end else nxt = ST_OD_RD;
            end
            ST_DIV_OLD:  if (div_rdy) nxt = ST_SLIDE_LO;
            ST_SLIDE_LO: if (issued_q && slide_done) nxt = slide_fail ? ST_FAIL : ST_OD_RD;
            ST_SLIDE_ONLY: if (issued_q && slide_done) nxt = slide_fail ? ST_FAIL : ST_DONE;
            ST_OD_RD: begin
                reg_req = 1'b1; reg_addr = A_ODIV; capture = 1'b1; nxt = ST_OD_WR;
            end
            ST_OD_WR: begin
                reg_req = 1'b1; reg_wr = 1'b1; reg_addr = A_ODIV;
                reg_wdata[ODIV_LSB +: ODIV_W] = ODIV_W'(2);
                tmr_load = 1'b1; nxt = ST_BYP_WAIT;
            end
            ST_BYP_WAIT: if (tmr_exp) nxt = ST_SEL_RD;
            ST_SEL_RD: begin
                reg_req = 1'b1; reg_addr = A_SEL; capture = 1'b1; nxt = ST_SEL_WR;
            end
            ST_SEL_WR: begin
                reg_req = 1'b1; reg_wr = 1'b1; reg_addr = A_SEL;
                reg_wdata[SEL_VCO] = 1'b0; nxt = ST_PD_RD;
            end
            ST_PD_RD: begin
                reg_req = 1'b1; capture = 1'b1;
                nxt = reg_rdata[CFG_PWDN] ? ST_PD_WR : ST_DIS_RD;
            end
            ST_PD_WR: begin
                reg_req = 1'b1; reg_wr = 1'b1;
                reg_wdata[CFG_PWDN] = 1'b0; nxt = ST_PD_RB;
            end
            ST_PD_RB: begin
                reg_req = 1'b1; tmr_load = 1'b1; nxt = ST_PD_WAIT;
            end
            ST_PD_WAIT: if (tmr_exp) nxt = ST_DIS_RD;
            ST_DIS_RD: begin
                reg_req = 1'b1; capture = 1'b1; nxt = ST_DIS_WR;
            end
            ST_DIS_WR: begin
                reg_req = 1'b1; reg_wr = 1'b1; reg_wdata[CFG_EN] = 1'b0;
                div_go = allow_q;
                nxt = allow_q ? ST_DIV_NEW : ST_COEFF_WR;
            end
            ST_DIV_NEW: if (div_rdy) nxt = ST_COEFF_WR;
            ST_COEFF_WR: begin
                reg_req = 1'b1; reg_wr = 1'b1; reg_addr = A_COEFF;
                reg_wdata = '0;
                reg_wdata[M_LSB +: M_W]   = tgt_m;
                reg_wdata[N_LSB +: N_W]   = allow_q ? nlo_q : tgt_n;
                reg_wdata[PL_LSB +: PL_W] = tgt_pl;
                nxt = ST_EN_RD;
            end
            ST_EN_RD: begin
                reg_req = 1'b1; capture = 1'b1; nxt = ST_EN_WR;
            end
            ST_EN_WR: begin
                reg_req = 1'b1; reg_wr = 1'b1; reg_wdata[CFG_EN] = 1'b1; nxt = ST_LDO_RD;
            end
            ST_LDO_RD: begin
                reg_req = 1'b1; capture = 1'b1;
                if (reg_rdata[CFG_LDO]) nxt = ST_LDO_WR;
                else begin
                    tmr_load = 1'b1; tmr_len = TW'(LOCK_CYC); nxt = ST_LOCK;
                end
            end
            ST_LDO_WR: begin
                reg_req = 1'b1; reg_wr = 1'b1; reg_wdata[CFG_LDO] = 1'b0;
                tmr_load = 1'b1; tmr_len = TW'(LOCK_CYC); nxt = ST_LOCK;
            end
            ST_LOCK: begin
                reg_req = 1'b1;
                if (reg_rdata[CFG_LOCK]) nxt = ST_VSEL_RD;
                else if (tmr_exp)        nxt = ST_FAIL;
            end
            ST_VSEL_RD: begin
                reg_req = 1'b1; reg_addr = A_SEL; capture = 1'b1; nxt = ST_VSEL_WR;
            end
            ST_VSEL_WR: begin
                reg_req = 1'b1; reg_wr = 1'b1; reg_addr = A_SEL;
                reg_wdata[SEL_VCO] = 1'b1; nxt = ST_RST_RD;
            end
            ST_RST_RD: begin
                reg_req = 1'b1; reg_addr = A_ODIV; capture = 1'b1;
                if (reg_rdata[ODIV_LSB +: ODIV_W] != '0) begin
                    tmr_load = 1'b1; nxt = ST_RST_WAIT;
                end else nxt = allow_q ? ST_SLIDE_UP : ST_DONE;
            end
            ST_RST_WAIT: if (tmr_exp) nxt = ST_RST_WR1;
            ST_RST_WR1, ST_RST_WR2: begin
                reg_req = 1'b1; reg_wr = 1'b1; reg_addr = A_ODIV;
                reg_wdata[ODIV_LSB +: ODIV_W] = '0;
                nxt = (st == ST_RST_WR1) ? ST_RST_WR2 : ST_RST_RB;
            end
            ST_RST_RB: begin
                reg_req = 1'b1; reg_addr = A_ODIV;
                nxt = allow_q ? ST_SLIDE_UP : ST_DONE;
            end
            ST_SLIDE_UP: if (issued_q && slide_done) nxt = slide_fail ? ST_FAIL : ST_DONE;
            ST_FAIL:     nxt = allow_q ? ST_RD_COEFF : ST_DONE;
            ST_DONE: begin
                done = 1'b1; nxt = ST_IDLE;
            end
            default:     nxt = ST_IDLE;
        endcase
    end

    // Sequencer state, latched targets, read captures and outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            allow_q  <= 1'b1;
            issued_q <= 1'b0;
            err_q    <= 1'b0;
            tgt_m    <= '0;
            tgt_n    <= '0;
            tgt_pl   <= '0;
            ref_q    <= '0;
            old_m    <= '0;
            old_pl   <= '0;
            nlo_q    <= '0;
            rd_q     <= '0;
        end else begin
            st       <= nxt;
            issued_q <= in_slide && (nxt == st);
            if (st == ST_IDLE && start) begin
                tgt_m   <= m_in;
                tgt_n   <= n_in;
                tgt_pl  <= pl_in;
                ref_q   <= ref_khz;
                allow_q <= 1'b1;
            end
            if (st == ST_FAIL) allow_q <= 1'b0;
            if (st == ST_RD_COEFF) begin
                old_m  <= reg_rdata[M_LSB +: M_W];
                old_pl <= reg_rdata[PL_LSB +: PL_W];
            end
            if (capture) rd_q <= reg_rdata;
            if (div_rdy) nlo_q <= div_sat;
            if (nxt == ST_DONE && st != ST_DONE) err_q <= (st == ST_FAIL);
        end
    end

    assign err = err_q;
endmodule

// File: rtl/pll_reprog_chk.sv
// Protocol checker for the reprogramming sequencer, bound to every instance.
module pll_reprog_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic done,
    input logic err,
    input logic busy,
    input logic reg_req,
    input logic slide_go
);
    // R9: completion is a single-cycle pulse.
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9: the sequencer is idle right after completion.
    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    // R9: the outcome flag moves only with the completion pulse.
    p_err_at_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(err) |-> done);
    // R10: no port activity while idle.
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!reg_req && !slide_go));
    // R10: a sequence begins only from a start pulse.
    p_busy_from_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
    // R7: each slide request is a single-cycle pulse.
    p_slide_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        slide_go |=> !slide_go);
endmodule

bind pll_reprog_seq pll_reprog_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done), .err(err),
    .busy(busy), .reg_req(reg_req), .slide_go(slide_go)
);

// File: tb/test_pll_reprog_seq.sv
module test_pll_reprog_seq;
    localparam int USC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  m_in = '0, n_in = '0;
    logic [5:0]  pl_in = '0;
    logic [19:0] ref_khz = '0;
    logic        done, err, reg_req, reg_wr, slide_go;
    logic [1:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic [7:0]  slide_ndiv;
    logic        slide_done, slide_fail;

    always #5 clk = ~clk;

    pll_reprog_seq #(.US_CYCLES(USC)) i_pll_reprog_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .m_in(m_in), .n_in(n_in),
        .pl_in(pl_in), .ref_khz(ref_khz), .done(done), .err(err),
        .reg_req(reg_req), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .slide_go(slide_go),
        .slide_ndiv(slide_ndiv), .slide_done(slide_done), .slide_fail(slide_fail)
    );

    typedef struct packed {
        logic [19:0] rk;
        logic        en, pd, ldo;
        logic [7:0]  om, on;
        logic [5:0]  opl;
        logic [7:0]  nm, nn;
        logic [5:0]  npl;
        logic        lock_ok;
        logic [3:0]  fail;
        logic        xerr;
        logic [3:0]  xsl;
        logic [7:0]  xfirst, xlast;
        logic [3:0]  xod;
        logic [7:0]  xcw;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{20'd12000,1'b1,1'b0,1'b0,8'd1,8'd100,6'd2,8'd1,8'd120,6'd2,1'b1,4'b0000,1'b0,4'd1,8'd120,8'd120,4'd0,8'd0},
        '{20'd12000,1'b1,1'b0,1'b0,8'd1,8'd100,6'd2,8'd2,8'd200,6'd3,1'b1,4'b0000,1'b0,4'd2,8'd84,8'd200,4'd3,8'd167},
        '{20'd12000,1'b0,1'b1,1'b1,8'd3,8'd50,6'd1,8'd1,8'd90,6'd1,1'b1,4'b0000,1'b0,4'd1,8'd90,8'd90,4'd3,8'd84},
        '{20'd12000,1'b1,1'b0,1'b0,8'd1,8'd100,6'd2,8'd2,8'd200,6'd3,1'b1,4'b0001,1'b0,4'd1,8'd84,8'd84,4'd3,8'd200},
        '{20'd12000,1'b0,1'b0,1'b0,8'd1,8'd100,6'd2,8'd2,8'd200,6'd3,1'b0,4'b0000,1'b1,4'd0,8'd0,8'd0,4'd2,8'd200},
        '{20'd12000,1'b1,1'b0,1'b0,8'd1,8'd100,6'd2,8'd2,8'd200,6'd3,1'b1,4'b0010,1'b0,4'd2,8'd84,8'd200,4'd6,8'd200},
        '{20'd12000,1'b1,1'b0,1'b0,8'd1,8'd100,6'd2,8'd1,8'd130,6'd2,1'b1,4'b0001,1'b0,4'd1,8'd130,8'd130,4'd3,8'd130},
        '{20'd12500,1'b1,1'b0,1'b0,8'd2,8'd170,6'd4,8'd1,8'd100,6'd4,1'b1,4'b0000,1'b0,4'd2,8'd160,8'd100,4'd3,8'd80},
        '{20'd38400,1'b0,1'b0,1'b0,8'd1,8'd50,6'd1,8'd3,8'd100,6'd2,1'b1,4'b0000,1'b0,4'd1,8'd100,8'd100,4'd3,8'd79}
    };

    // Environment model: registers, lock, slide engine and monitors.
    logic        mdl_load = 1'b0;
    vec_t        ld;
    logic [31:0] m_cfg, m_coeff, m_sel, m_od;
    logic [3:0]  lock_cnt, slides, od_wr, fail_mask;
    logic        lock_ok, ord_bad, sl_busy;
    logic [7:0]  first_n, last_n, cw_n, sl_tgt;
    logic [1:0]  sl_cnt;
    int          cyc, od2_cyc, done_cnt;
    logic        locked;

    assign locked = lock_cnt >= 4'd5;

    always_comb begin
        case (reg_addr)
            2'd0:    reg_rdata = {m_cfg[31:18], locked, m_cfg[16:0]};
            2'd1:    reg_rdata = m_coeff;
            2'd2:    reg_rdata = m_sel;
            default: reg_rdata = m_od;
        endcase
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        slide_done <= 1'b0;
        if (done) done_cnt <= done_cnt + 1;
        if (mdl_load) begin
            m_cfg     <= {27'd0, ld.ldo, 2'b00, ld.pd, ld.en};
            m_coeff   <= {10'd0, ld.opl, ld.on, ld.om};
            m_sel     <= {31'd0, ld.en};
            m_od      <= 32'd0;
            lock_cnt  <= ld.en ? 4'd7 : 4'd0;
            lock_ok   <= ld.lock_ok;
            fail_mask <= ld.fail;
            slides <= '0; od_wr <= '0; first_n <= '0; last_n <= '0; cw_n <= '0;
            ord_bad <= 1'b0; sl_busy <= 1'b0; slide_fail <= 1'b0; done_cnt <= 0;
        end else begin
            if (reg_req && reg_wr && reg_addr == 2'd0 && !reg_wdata[0]) lock_cnt <= '0;
            else if (m_cfg[0] && lock_ok && lock_cnt < 4'd7) lock_cnt <= lock_cnt + 4'd1;
            if (reg_req && reg_wr) begin
                case (reg_addr)
                    2'd0: m_cfg <= reg_wdata & ~(32'd1 << 17);
                    2'd1: begin
                        m_coeff <= reg_wdata;
                        cw_n    <= reg_wdata[15:8];
                        if (m_sel[0] || m_cfg[0]) ord_bad <= 1'b1;
                    end
                    2'd2: begin
                        m_sel <= reg_wdata;
                        if (!reg_wdata[0] && (m_od[13:8] != 6'd2 || cyc - od2_cyc < 2 * USC))
                            ord_bad <= 1'b1;
                    end
                    default: begin
                        m_od  <= reg_wdata;
                        od_wr <= od_wr + 4'd1;
                        if (reg_wdata[13:8] == 6'd2) od2_cyc <= cyc;
                    end
                endcase
            end
            if (slide_go) begin
                sl_busy <= 1'b1; sl_cnt <= 2'd3; sl_tgt <= slide_ndiv;
                if (slides == 4'd0) first_n <= slide_ndiv;
                last_n <= slide_ndiv;
                slides <= slides + 4'd1;
            end else if (sl_busy) begin
                if (sl_cnt == 2'd0) begin
                    slide_done <= 1'b1;
                    slide_fail <= fail_mask[slides - 4'd1];
                    if (!fail_mask[slides - 4'd1]) m_coeff[15:8] <= sl_tgt;
                    sl_busy <= 1'b0;
                end else sl_cnt <= sl_cnt - 2'd1;
            end
        end
    end

    int nchk = 0, nfail = 0;

    task automatic check(input bit ok, input string what, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s act=%0d exp=%0d", what, act, exp);
        end
    endtask

    task automatic load_and_start(input vec_t v);
        ld = v;
        mdl_load = 1'b1;
        @(posedge clk); #1;
        mdl_load = 1'b0;
        m_in = v.nm; n_in = v.nn; pl_in = v.npl; ref_khz = v.rk;
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
    endtask

    task automatic wait_done();
        for (int k = 0; k < 20000; k++) begin
            if (done) break;
            @(posedge clk); #1;
        end
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        load_and_start(v);
        wait_done();
        check(done == 1'b1, $sformatf("R9 vec%0d done seen", idx), done, 1);
        check(err == v.xerr, $sformatf("R9 R5 vec%0d err", idx), err, v.xerr);
        repeat (3) @(posedge clk); #1;
        check(slides == v.xsl, $sformatf("R1 R8 vec%0d slide count", idx), slides, v.xsl);
        if (v.xsl != 0) begin
            check(first_n == v.xfirst, $sformatf("R2 vec%0d first slide N", idx), first_n, v.xfirst);
            check(last_n == v.xlast, $sformatf("R7 vec%0d last slide N", idx), last_n, v.xlast);
        end
        check(od_wr == v.xod, $sformatf("R3 R6 vec%0d divider writes", idx), od_wr, v.xod);
        check(cw_n == v.xcw, $sformatf("R4 vec%0d coefficient N written", idx), cw_n, v.xcw);
        check(!ord_bad, $sformatf("R3 vec%0d bypass order and settle", idx), ord_bad, 0);
        if (!v.xerr) begin
            check(m_coeff == {10'd0, v.npl, v.nn, v.nm}, $sformatf("R7 vec%0d final coeff", idx),
                  m_coeff, {10'd0, v.npl, v.nn, v.nm});
            check(m_cfg[1:0] == 2'b01, $sformatf("R4 vec%0d cfg enable/pwdn", idx), m_cfg[1:0], 1);
            check(m_cfg[4] == 1'b0, $sformatf("R5 vec%0d lock-detect-off", idx), m_cfg[4], 0);
            check(m_sel[0] == 1'b1, $sformatf("R6 vec%0d VCO select", idx), m_sel[0], 1);
            check(m_od[13:8] == 6'd0, $sformatf("R6 vec%0d divider restored", idx), m_od[13:8], 0);
        end else begin
            check(m_sel[0] == 1'b0, $sformatf("R5 vec%0d stays in bypass", idx), m_sel[0], 0);
        end
        check(done_cnt == 1, $sformatf("R9 vec%0d single done", idx), done_cnt, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL R9 watchdog act=hung exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        cyc = 0; od2_cyc = 0;
        ld = VEC[0];
        mdl_load = 1'b1;
        repeat (3) @(posedge clk); #1;
        mdl_load = 1'b0;
        rst_n = 1'b1;
        @(posedge clk); #1;
        check(done == 1'b0 && err == 1'b0, "R9 reset outputs", {done, err}, 0);
        check(reg_req == 1'b0 && slide_go == 1'b0, "R10 reset idle", {reg_req, slide_go}, 0);

        for (int i = 0; i < NV; i++) run_vec(VEC[i], i);

        // R10: a second start during a run is ignored.
        load_and_start(VEC[1]);
        repeat (20) @(posedge clk); #1;
        n_in = 8'd33; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        wait_done();
        repeat (60) @(posedge clk); #1;
        check(done_cnt == 1, "R10 start while busy ignored", done_cnt, 1);
        check(m_coeff[15:8] == 8'd200, "R10 target unchanged by late start", m_coeff[15:8], 200);

        // Reset mid-sequence returns the block to a quiet idle state.
        load_and_start(VEC[1]);
        repeat (15) @(posedge clk); #1;
        rst_n = 1'b0;
        repeat (2) @(posedge clk); #1;
        check(done == 1'b0 && reg_req == 1'b0 && slide_go == 1'b0, "R10 reset mid-run",
              {done, reg_req, slide_go}, 0);
        rst_n = 1'b1;
        repeat (5) @(posedge clk); #1;
        check(reg_req == 1'b0 && slide_go == 1'b0, "R10 idle after reset", {reg_req, slide_go}, 0);

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule